// File: doc/BRIEF.md
# Processor Trap Entry Sequencer

This block computes the architectural state update that a 64-bit processor with register windows makes when it enters a trap. A one-cycle `trap_req` strobe presents a 9-bit trap type together with the current trap level, processor state word, condition codes, address space identifier, window pointer, free-window count, program counters and trap base address. From these the block produces the values to write: a trap-stack record, a new trap level, a new processor state word, an optional new window pointer and the trap vector for both program counters.

The control is a three-state machine. `ST_IDLE` waits for a request. A request whose trap level is below the maximum moves to `ST_COMMIT` and every other request moves to `ST_FAULT`. Each of the two result states lasts one cycle and then returns to `ST_IDLE`, unless a new request arrives in that cycle, in which case the machine takes the same choice again. In `ST_COMMIT` the `commit` strobe tells the surrounding core to write all presented values. In `ST_FAULT` only `err_state` is raised, and nothing is to be written.

Trap types use a 9-bit code. The numeric codes listed in the requirements are the ones the block decodes.

Top module: `trap_entry_seq`

## Requirements
- R1: A request with `cur_tl` >= MAXTL (default 5) produces, in the following cycle, `done`=1, `err_state`=1, `commit`=0 and `cwp_we`=0.
- R2: On commit `new_tl` = `cur_tl`+1. The RED bit (bit 5 of the state word) is set when `cur_tl` = MAXTL-1. Otherwise it keeps its old value.
- R3: On commit `ts_idx` = `new_tl` AND the trap-stack level mask (default all ones of the level width).
- R4: On commit `ts_tstate`[39:32]=CCR, [31:24]=ASI, [19:8]=state word AND 0xF3F, and the window pointer sits zero-extended in [7:0]. Bits 23:20 are zero. `ts_tpc`, `ts_tnpc` and `ts_tt` carry the old PC, the old NPC and the trap type.
- R5: The new state word sets PEF (bit 4) and PRIV (bit 2). It clears AM (bit 3) and IE (bit 1). It keeps MM (bits 7:6), TLE (bit 8) and CLE (bit 9). Exactly one of AG (bit 0), MG (bit 10) and IG (bit 11) is set.
- R6: Type 0x060 selects IG. Types 0x008 and 0x030, and the ranges 0x064–0x067, 0x068–0x06B and 0x06C–0x06F, select MG. All other types select AG.
- R7: Type 0x024 (clean window) gives `cwp_we`=1 and `new_cwp` = (CWP-1) mod NWIN, with NWIN defaulting to 8.
- R8: Types 0x080–0x0BF (spill) give `cwp_we`=1 and `new_cwp` = (CWP-CANSAVE-2) mod NWIN. Types 0x0C0–0x0FF (fill) give `cwp_we`=1 and `new_cwp` = (CWP+1) mod NWIN.
- R9: All other types, including trap instructions 0x100–0x17F and undefined codes 0x180–0x1FF, give `cwp_we`=0 and `new_cwp` = CWP.
- R10: `new_pc` takes the trap base with bits 14:0 cleared. Bit 14 is set when `new_tl` > 1, and bits 13:5 hold the trap type. `new_npc` = `new_pc`+4.
- R11: `done` is high exactly in the cycle after each cycle with `trap_req` high, so back-to-back requests give back-to-back results.
- R12: During and right after reset, `done`, `commit` and `err_state` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_req | input | 1 | Trap request strobe |
| trap_type | input | 9 | Trap type code |
| cur_tl | input | TL_W | Current trap level |
| cur_pstate | input | 12 | Current processor state word |
| cur_ccr | input | 8 | Condition code register |
| cur_asi | input | 8 | Address space identifier |
| cur_cwp | input | CWP_W | Current window pointer |
| cur_cansave | input | CWP_W | Windows free to save |
| cur_pc | input | ADDR_W | Current PC |
| cur_npc | input | ADDR_W | Current next PC |
| cur_tba | input | ADDR_W | Trap base address |
| done | output | 1 | Result cycle for a request |
| commit | output | 1 | Write all presented values |
| err_state | output | 1 | Trap refused: level at maximum |
| ts_idx | output | TL_W | Trap-stack entry index |
| ts_tstate | output | 40 | Packed saved state |
| ts_tpc | output | ADDR_W | Saved PC |
| ts_tnpc | output | ADDR_W | Saved next PC |
| ts_tt | output | 9 | Saved trap type |
| new_tl | output | TL_W | New trap level |
| new_pstate | output | 12 | New processor state word |
| cwp_we | output | 1 | Window pointer write enable |
| new_cwp | output | CWP_W | New window pointer |
| new_pc | output | ADDR_W | Trap vector |
| new_npc | output | ADDR_W | Trap vector plus 4 |

## Verification
The hardest corner to reach is the wrap of the window pointer on a spill when CWP is small and CANSAVE is large. There the subtraction crosses zero by up to NWIN+1 windows, and it only occurs together with a spill-class type code. The random stimulus draws trap types from weighted classes so that spill, fill and clean-window codes appear often, and it draws CWP and CANSAVE over their full ranges. Directed cases add CWP=0 with CANSAVE=NWIN-1, and the trap levels MAXTL-1, MAXTL and the largest encodable level.

// File: rtl/trap_seq_pkg.sv
`timescale 1ns/1ps
package trap_seq_pkg;

    localparam int TT_W     = 9;
    localparam int PS_W     = 12;
    localparam int TSTATE_W = 40;

    // trap type codes decoded by the block
    localparam logic [TT_W-1:0] TT_INST_FAULT = 9'h008;
    localparam logic [TT_W-1:0] TT_CLEAN_WIN  = 9'h024;
    localparam logic [TT_W-1:0] TT_DATA_FAULT = 9'h030;
    localparam logic [TT_W-1:0] TT_INTR_VEC   = 9'h060;
    localparam logic [TT_W-1:0] TT_IMISS_BASE = 9'h064;
    localparam logic [TT_W-1:0] TT_DMISS_BASE = 9'h068;
    localparam logic [TT_W-1:0] TT_DPROT_BASE = 9'h06C;
    localparam logic [TT_W-1:0] TT_WIN_MASK   = 9'h1C0;
    localparam logic [TT_W-1:0] TT_SPILL_BASE = 9'h080;
    localparam logic [TT_W-1:0] TT_FILL_BASE  = 9'h0C0;

    // state word bit positions
    localparam int PS_AG   = 0;
    localparam int PS_IE   = 1;
    localparam int PS_PRIV = 2;
    localparam int PS_AM   = 3;
    localparam int PS_PEF  = 4;
    localparam int PS_RED  = 5;
    localparam int PS_MG   = 10;
    localparam int PS_IG   = 11;

    localparam logic [PS_W-1:0] PS_SAVE_MASK = 12'hF3F;
    localparam logic [PS_W-1:0] PS_KEEP_MASK = 12'h3C0;  // MM, TLE, CLE

    typedef enum logic [1:0] {
        GL_ALT  = 2'd0,
        GL_MMU  = 2'd1,
        GL_INTR = 2'd2
    } glob_sel_e;

    typedef enum logic [1:0] {
        WM_NONE  = 2'd0,
        WM_CLEAN = 2'd1,
        WM_SPILL = 2'd2,
        WM_FILL  = 2'd3
    } win_move_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_COMMIT = 2'd1,
        ST_FAULT  = 2'd2
    } seq_state_e;

endpackage

// File: rtl/trap_class_dec.sv
`timescale 1ns/1ps
module trap_class_dec
    import trap_seq_pkg::*;
(
    input  logic [TT_W-1:0] tt,
    output glob_sel_e       glob,
    output win_move_e       wmove
);

    localparam int N_RANGE = 3;

    logic [N_RANGE-1:0] in_range;
    logic [TT_W-1:0]    range_base [N_RANGE];

    assign range_base[0] = TT_IMISS_BASE;
    assign range_base[1] = TT_DMISS_BASE;
    assign range_base[2] = TT_DPROT_BASE;

    // each miss/protection group spans four consecutive codes
    generate
        for (genvar g = 0; g < N_RANGE; g++) begin : g_rng
            assign in_range[g] = (tt[TT_W-1:2] == range_base[g][TT_W-1:2]);
        end
    endgenerate

    always_comb begin
        if (tt == TT_INTR_VEC) begin
            glob = GL_INTR;
        end else if ((tt == TT_INST_FAULT) || (tt == TT_DATA_FAULT) || (|in_range)) begin
            glob = GL_MMU;
        end else begin
            glob = GL_ALT;
        end
    end

    always_comb begin
        if (tt == TT_CLEAN_WIN) begin
            wmove = WM_CLEAN;
        end else if ((tt & TT_WIN_MASK) == TT_SPILL_BASE) begin
            wmove = WM_SPILL;
        end else if ((tt & TT_WIN_MASK) == TT_FILL_BASE) begin
            wmove = WM_FILL;
        end else begin
            wmove = WM_NONE;
        end
    end

endmodule

// File: rtl/trap_cwp_calc.sv
`timescale 1ns/1ps
module trap_cwp_calc
    import trap_seq_pkg::*;
#(
    parameter int NWIN  = 8,
    parameter int CWP_W = $clog2(NWIN)
) (
    input  win_move_e        wmove,
    input  logic [CWP_W-1:0] cwp,
    input  logic [CWP_W-1:0] cansave,
    output logic [CWP_W-1:0] next_cwp,
    output logic             moved
);

    localparam int EXT_W = CWP_W + 2;
    localparam logic [EXT_W-1:0] NW1 = EXT_W'(NWIN);
    localparam logic [EXT_W-1:0] NW2 = EXT_W'(2 * NWIN);

    logic [EXT_W-1:0] raw;

    // biased by whole multiples of NWIN so the sum never goes negative
    always_comb begin
        unique case (wmove)
            WM_CLEAN: raw = EXT_W'(cwp) + NW1 - EXT_W'(1);
            WM_SPILL: raw = EXT_W'(cwp) + NW2 - EXT_W'(cansave) - EXT_W'(2);
            WM_FILL:  raw = EXT_W'(cwp) + EXT_W'(1);
            default:  raw = EXT_W'(cwp);
        endcase
    end

    assign moved = (wmove != WM_NONE);

    generate
        if ((NWIN & (NWIN - 1)) == 0) begin : g_pow2
            assign next_cwp = raw[CWP_W-1:0];
        end else begin : g_mod
            logic [EXT_W-1:0] red;
            assign red      = raw % NW1;
            assign next_cwp = red[CWP_W-1:0];
        end
    endgenerate

endmodule

// File: rtl/trap_vec_gen.sv
`timescale 1ns/1ps
module trap_vec_gen
    import trap_seq_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic [ADDR_W-1:0] tba,
    input  logic [TT_W-1:0]   tt,
    input  logic              nested,
    output logic [ADDR_W-1:0] vec,
    output logic [ADDR_W-1:0] vec_next
);

    localparam int OFF_W = 15;

    assign vec      = {tba[ADDR_W-1:OFF_W], nested, tt, 5'b00000};
    assign vec_next = vec + ADDR_W'(4);

endmodule

// File: rtl/trap_entry_seq.sv
`timescale 1ns/1ps
module trap_entry_seq
    import trap_seq_pkg::*;
#(
    parameter int MAXTL       = 5,
    parameter int NWIN        = 8,
    parameter int ADDR_W      = 64,
    parameter int TS_LVL_MASK = 7,
    localparam int TL_W       = $clog2(MAXTL + 1),
    localparam int CWP_W      = $clog2(NWIN)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                trap_req,
    input  logic [TT_W-1:0]     trap_type,
    input  logic [TL_W-1:0]     cur_tl,
    input  logic [PS_W-1:0]     cur_pstate,
    input  logic [7:0]          cur_ccr,
    input  logic [7:0]          cur_asi,
    input  logic [CWP_W-1:0]    cur_cwp,
    input  logic [CWP_W-1:0]    cur_cansave,
    input  logic [ADDR_W-1:0]   cur_pc,
    input  logic [ADDR_W-1:0]   cur_npc,
    input  logic [ADDR_W-1:0]   cur_tba,
    output logic                done,
    output logic                commit,
    output logic                err_state,
    output logic [TL_W-1:0]     ts_idx,
    output logic [TSTATE_W-1:0] ts_tstate,
    output logic [ADDR_W-1:0]   ts_tpc,
    output logic [ADDR_W-1:0]   ts_tnpc,
    output logic [TT_W-1:0]     ts_tt,
    output logic [TL_W-1:0]     new_tl,
    output logic [PS_W-1:0]     new_pstate,
    output logic                cwp_we,
    output logic [CWP_W-1:0]    new_cwp,
    output logic [ADDR_W-1:0]   new_pc,
    output logic [ADDR_W-1:0]   new_npc
);

    localparam logic [TL_W-1:0] TL_MAX  = TL_W'(MAXTL);
    localparam logic [TL_W-1:0] TL_LAST = TL_W'(MAXTL - 1);
    localparam logic [TL_W-1:0] LVL_MSK = TL_W'(TS_LVL_MASK);

    seq_state_e state_q, state_d;

    // ---------------- combinational next-value datapath ----------------
    glob_sel_e        glob;
    win_move_e        wmove;
    logic [CWP_W-1:0] cwp_calc;
    logic             cwp_moves;
    logic [ADDR_W-1:0] vec, vec_next;
    logic             tl_ok, near_max, nested;
    logic [TL_W-1:0]  tl_inc;
    logic [PS_W-1:0]  ps_calc;
    logic [TSTATE_W-1:0] tstate_calc;

    trap_class_dec u_cls (
        .tt    (trap_type),
        .glob  (glob),
        .wmove (wmove)
    );

    trap_cwp_calc #(.NWIN(NWIN), .CWP_W(CWP_W)) u_cwp (
        .wmove    (wmove),
        .cwp      (cur_cwp),
        .cansave  (cur_cansave),
        .next_cwp (cwp_calc),
        .moved    (cwp_moves)
    );

    assign tl_ok    = (cur_tl < TL_MAX);
    assign near_max = (cur_tl == TL_LAST);
    assign tl_inc   = cur_tl + TL_W'(1);
    assign nested   = (tl_inc > TL_W'(1));

    trap_vec_gen #(.ADDR_W(ADDR_W)) u_vec (
        .tba      (cur_tba),
        .tt       (trap_type),
        .nested   (nested),
        .vec      (vec),
        .vec_next (vec_next)
    );

    always_comb begin
        ps_calc          = cur_pstate & PS_KEEP_MASK;
        ps_calc[PS_RED]  = cur_pstate[PS_RED] | near_max;
        ps_calc[PS_PEF]  = 1'b1;
        ps_calc[PS_PRIV] = 1'b1;
        unique case (glob)
            GL_INTR: ps_calc[PS_IG] = 1'b1;
            GL_MMU:  ps_calc[PS_MG] = 1'b1;
            default: ps_calc[PS_AG] = 1'b1;
        endcase
    end

    always_comb begin
        tstate_calc              = '0;
        tstate_calc[39:32]       = cur_ccr;
        tstate_calc[31:24]       = cur_asi;
        tstate_calc[19:8]        = cur_pstate & PS_SAVE_MASK;
        tstate_calc[CWP_W-1:0]   = cur_cwp;
    end

    // ---------------- result registers ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ts_idx     <= '0;
            ts_tstate  <= '0;
            ts_tpc     <= '0;
            ts_tnpc    <= '0;
            ts_tt      <= '0;
            new_tl     <= '0;
            new_pstate <= '0;
            new_cwp    <= '0;
            new_pc     <= '0;
            new_npc    <= '0;
        end else if (trap_req) begin
            ts_idx     <= tl_inc & LVL_MSK;
            ts_tstate  <= tstate_calc;
            ts_tpc     <= cur_pc;
            ts_tnpc    <= cur_npc;
            ts_tt      <= trap_type;
            new_tl     <= tl_inc;
            new_pstate <= ps_calc;
            new_cwp    <= cwp_calc;
            new_pc     <= vec;
            new_npc    <= vec_next;
        end
    end

    logic move_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            move_q <= 1'b0;
        end else if (trap_req) begin
            move_q <= cwp_moves;
        end
    end

    // ---------------- state machine ----------------
    always_comb begin
        state_d = ST_IDLE;
        if (trap_req) begin
            state_d = tl_ok ? ST_COMMIT : ST_FAULT;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        done      = 1'b0;
        commit    = 1'b0;
        err_state = 1'b0;
        cwp_we    = 1'b0;
        unique case (state_q)
            ST_COMMIT: begin
                done   = 1'b1;
                commit = 1'b1;
                cwp_we = move_q;
            end
            ST_FAULT: begin
                done      = 1'b1;
                err_state = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/trap_entry_chk.sv
`timescale 1ns/1ps
module trap_entry_chk
    import trap_seq_pkg::*;
#(
    parameter int MAXTL  = 5,
    parameter int NWIN   = 8,
    parameter int ADDR_W = 64,
    localparam int TL_W  = $clog2(MAXTL + 1),
    localparam int CWP_W = $clog2(NWIN)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              trap_req,
    input logic [TT_W-1:0]   trap_type,
    input logic [TL_W-1:0]   cur_tl,
    input logic [CWP_W-1:0]  cur_cwp,
    input logic              done,
    input logic              commit,
    input logic              err_state,
    input logic [TT_W-1:0]   ts_tt,
    input logic [TL_W-1:0]   new_tl,
    input logic [PS_W-1:0]   new_pstate,
    input logic              cwp_we,
    input logic [CWP_W-1:0]  new_cwp,
    input logic [ADDR_W-1:0] new_pc
);

    p_fault_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        err_state |-> (!commit && !cwp_we));

    p_fault_at_max_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && (cur_tl >= TL_W'(MAXTL))) |=> err_state);

    p_tl_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && (cur_tl < TL_W'(MAXTL))) |=> (commit && (new_tl == $past(cur_tl) + TL_W'(1))));

    p_ps_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (new_pstate[PS_PEF] && new_pstate[PS_PRIV] && !new_pstate[PS_AM] &&
                    !new_pstate[PS_IE] &&
                    $onehot({new_pstate[PS_IG], new_pstate[PS_MG], new_pstate[PS_AG]})));

    p_cwp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && (trap_type >= 9'h100)) |=> (!cwp_we && (new_cwp == $past(cur_cwp))));

    p_vec_fields_r10: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> ((new_pc[4:0] == 5'd0) && (new_pc[13:5] == ts_tt)));

    p_done_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |=> done);

    p_done_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_req |=> !done);

    p_outcome_one_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $onehot({commit, err_state}));

endmodule

bind trap_entry_seq trap_entry_chk #(.MAXTL(MAXTL), .NWIN(NWIN), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_trap_entry_seq.sv
`timescale 1ns/1ps
module sim_trap_entry_seq;

    localparam int MAXTL  = 5;
    localparam int NWIN   = 8;
    localparam int ADDR_W = 64;
    localparam int TL_W   = $clog2(MAXTL + 1);
    localparam int CWP_W  = $clog2(NWIN);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              trap_req = 1'b0;
    logic [8:0]        trap_type = '0;
    logic [TL_W-1:0]   cur_tl = '0;
    logic [11:0]       cur_pstate = '0;
    logic [7:0]        cur_ccr = '0;
    logic [7:0]        cur_asi = '0;
    logic [CWP_W-1:0]  cur_cwp = '0;
    logic [CWP_W-1:0]  cur_cansave = '0;
    logic [ADDR_W-1:0] cur_pc = '0;
    logic [ADDR_W-1:0] cur_npc = '0;
    logic [ADDR_W-1:0] cur_tba = '0;
    logic              done, commit, err_state, cwp_we;
    logic [TL_W-1:0]   ts_idx, new_tl;
    logic [39:0]       ts_tstate;
    logic [ADDR_W-1:0] ts_tpc, ts_tnpc, new_pc, new_npc;
    logic [8:0]        ts_tt;
    logic [11:0]       new_pstate;
    logic [CWP_W-1:0]  new_cwp;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    trap_entry_seq #(.MAXTL(MAXTL), .NWIN(NWIN), .ADDR_W(ADDR_W)) u0 (.*);

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // ---------------- expected-value model ----------------
    function automatic logic [11:0] exp_ps(input logic [8:0] tt, input int tl, input logic [11:0] ps);
        logic [11:0] r;
        r = (ps & 12'h3E0) | 12'h014;
        if (tl == MAXTL - 1) r = r | 12'h020;
        if (tt == 9'h060) r = r | 12'h800;
        else if (tt == 9'h008 || tt == 9'h030 || (tt >= 9'h064 && tt <= 9'h06F)) r = r | 12'h400;
        else r = r | 12'h001;
        return r;
    endfunction

    function automatic int exp_cwp(input logic [8:0] tt, input int cwp, input int cs, output bit mv);
        mv = 1'b1;
        if (tt == 9'h024) return (cwp + NWIN - 1) % NWIN;
        if (tt >= 9'h080 && tt <= 9'h0BF) return (cwp + 2 * NWIN - cs - 2) % NWIN;
        if (tt >= 9'h0C0 && tt <= 9'h0FF) return (cwp + 1) % NWIN;
        mv = 1'b0;
        return cwp;
    endfunction

    task automatic drive(input logic [8:0] tt, input int tl, input logic [11:0] ps, input int cwp, input int cs);
        trap_type   = tt;
        cur_tl      = TL_W'(tl);
        cur_pstate  = ps;
        cur_ccr     = 8'($urandom);
        cur_asi     = 8'($urandom);
        cur_cwp     = CWP_W'(cwp);
        cur_cansave = CWP_W'(cs);
        cur_pc      = {$urandom, $urandom};
        cur_npc     = {$urandom, $urandom};
        cur_tba     = {$urandom, $urandom};
        trap_req    = 1'b1;
    endtask

    task automatic verify(input logic [8:0] tt, input int tl, input logic [11:0] ps, input int cwp,
                          input int cs, input logic [7:0] ccr, input logic [7:0] asi,
                          input logic [63:0] pc, input logic [63:0] npc, input logic [63:0] tba);
        bit mv;
        int ec;
        logic [39:0] ets;
        logic [63:0] ev;
        chk(done == 1'b1, "R11 done", 64'(done), 64'd1);
        if (tl >= MAXTL) begin
            chk(err_state == 1'b1, "R1 err_state", 64'(err_state), 64'd1);
            chk(commit == 1'b0, "R1 commit", 64'(commit), 64'd0);
            chk(cwp_we == 1'b0, "R1 cwp_we", 64'(cwp_we), 64'd0);
            return;
        end
        chk(commit == 1'b1 && err_state == 1'b0, "R1 commit on ok level", 64'(commit), 64'd1);
        chk(int'(new_tl) == tl + 1, "R2 new_tl", 64'(new_tl), 64'(tl + 1));
        chk(int'(ts_idx) == ((tl + 1) & 7), "R3 ts_idx", 64'(ts_idx), 64'((tl + 1) & 7));
        ets = {ccr, asi, 4'h0, ps & 12'hF3F, 8'(cwp)};
        chk(ts_tstate == ets, "R4 tstate", 64'(ts_tstate), 64'(ets));
        chk(ts_tpc == pc && ts_tnpc == npc && ts_tt == tt, "R4 saved pc/npc/tt", ts_tpc, pc);
        chk(new_pstate == exp_ps(tt, tl, ps), "R5 R6 R2 pstate", 64'(new_pstate), 64'(exp_ps(tt, tl, ps)));
        ec = exp_cwp(tt, cwp, cs, mv);
        chk(cwp_we == mv, "R7 R8 R9 cwp_we", 64'(cwp_we), 64'(mv));
        chk(int'(new_cwp) == ec, "R7 R8 R9 new_cwp", 64'(new_cwp), 64'(ec));
        ev = (tba & ~64'h7FFF) | ((tl >= 1) ? 64'h4000 : 64'h0) | (64'(tt) << 5);
        chk(new_pc == ev, "R10 new_pc", new_pc, ev);
        chk(new_npc == ev + 64'd4, "R10 new_npc", new_npc, ev + 64'd4);
    endtask

    task automatic one_trap(input logic [8:0] tt, input int tl, input logic [11:0] ps, input int cwp, input int cs);
        logic [7:0] ccr, asi;
        logic [63:0] pc, npc, tba;
        @(negedge clk);
        drive(tt, tl, ps, cwp, cs);
        ccr = cur_ccr; asi = cur_asi; pc = cur_pc; npc = cur_npc; tba = cur_tba;
        @(negedge clk);
        trap_req = 1'b0;
        verify(tt, tl, ps, cwp, cs, ccr, asi, pc, npc, tba);
        @(negedge clk);
        chk(done == 1'b0, "R11 done drops", 64'(done), 64'd0);
    endtask

    function automatic logic [8:0] pick_tt();
        int k;
        k = $urandom_range(0, 9);
        case (k)
            0: return 9'h060;
            1: return ($urandom_range(0, 1) == 0) ? 9'h008 : 9'h030;
            2: return 9'(9'h064 + $urandom_range(0, 11));
            3: return 9'h024;
            4, 5: return 9'(9'h080 + $urandom_range(0, 63));
            6: return 9'(9'h0C0 + $urandom_range(0, 63));
            7: return 9'(9'h100 + $urandom_range(0, 255));
            default: return 9'($urandom_range(0, 511));
        endcase
    endfunction

    initial begin
        #(200000 * 5);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [8:0] t1, t2;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        chk(done == 1'b0 && commit == 1'b0 && err_state == 1'b0, "R12 reset outputs",
            64'({done, commit, err_state}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(done == 1'b0 && commit == 1'b0 && err_state == 1'b0, "R12 after reset",
            64'({done, commit, err_state}), 64'd0);

        // directed corners
        one_trap(9'h024, 0, 12'h000, 0, 3);             // R7 wrap at 0
        one_trap(9'h080, 1, 12'hFFF, 0, NWIN - 1);      // R8 deepest spill wrap
        one_trap(9'h0BF, 2, 12'h0C2, 1, 0);             // R8 spill
        one_trap(9'h0C0, 3, 12'h300, NWIN - 1, 2);      // R8 fill wrap
        one_trap(9'h060, MAXTL - 1, 12'h001, 4, 1);     // R2 RED, R6 IG
        one_trap(9'h067, 0, 12'h020, 2, 2);             // R6 MG range end, RED kept
        one_trap(9'h06C, 2, 12'h000, 2, 2);             // R6
        one_trap(9'h070, 2, 12'h000, 2, 2);             // R6 just past range
        one_trap(9'h17F, 1, 12'h000, 5, 5);             // R9
        one_trap(9'h1FF, 0, 12'h000, 6, 6);             // R9 undefined code
        one_trap(9'h024, MAXTL, 12'h000, 3, 3);         // R1
        one_trap(9'h080, (1 << TL_W) - 1, 12'h000, 3, 3); // R1 top level

        // back-to-back requests, R11
        @(negedge clk);
        t1 = 9'h0C5; t2 = 9'h008;
        drive(t1, 1, 12'h000, 2, 0);
        @(negedge clk);
        chk(done && commit && ts_tt == t1, "R11 first of pair", 64'(ts_tt), 64'(t1));
        drive(t2, MAXTL, 12'h000, 2, 0);
        @(negedge clk);
        trap_req = 1'b0;
        chk(done && err_state && !commit, "R11 R1 second of pair", 64'({done, err_state, commit}), 64'h6);
        @(negedge clk);
        chk(!done, "R11 pair ends", 64'(done), 64'd0);

        // constrained random
        for (int i = 0; i < 400; i++) begin
            one_trap(pick_tt(), $urandom_range(0, (1 << TL_W) - 1), 12'($urandom),
                     $urandom_range(0, NWIN - 1), $urandom_range(0, NWIN - 1));
        end

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule